// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by fetching two page-table entries from memory, one after the other. A request carries the virtual address and a write flag. The walker takes the table root from a base input at the moment it accepts the request. It reads the first-level entry and checks that the entry is valid. It then reads the second-level entry from the table that the first entry points to, and checks that entry for validity and, on a write, for write permission. It ends with either a translated address or a fault code, each shown for exactly one cycle.

Memory is reached through a single-beat read port. The walker raises a read strobe for one cycle with an address, then waits for as many cycles as the memory needs until the memory returns the matching data with a valid strobe. Only one walk is in flight at a time. While a walk is running, the walker reports busy and drops any new request.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy, mem_rd_en, done_valid and fault_valid are all 0.
- R2: The first read goes to root_base + 4*VA[31:22]. root_base and the request are sampled only in the cycle the request is accepted.
- R3: The second read goes to the concatenation {first entry bits [31:12], VA[21:12], 2'b00}. This is the first-level frame times 4096 plus 4 times the second index.
- R4: An entry holds the valid flag in bit 0, the writable flag in bit 1 and the frame number in bits [31:12]. A successful walk pulses done_valid for one cycle with done_paddr = {second entry bits [31:12], VA[11:0]}.
- R5: A first-level entry with bit 0 clear ends the walk with fault_kind 2'b01. No second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with fault_kind 2'b10.
- R7: A write request whose second-level entry has bit 1 clear ends with fault_kind 2'b11. A read request through the same entry completes normally. Bit 1 of the first-level entry is not consulted.
- R8: busy is 1 from the cycle after acceptance until the outcome cycle. In the cycle after the outcome it is 0. Requests and root_base changes made while busy have no effect on the current walk and start no walk of their own.
- R9: Each level issues exactly one read, and mem_rd_en is a one-cycle pulse. No new read is issued while one is outstanding, and the walk waits any number of cycles for mem_rd_valid.
- R10: done_valid and fault_valid are never 1 in the same cycle. fault_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted when busy is 0 |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| root_base | input | 32 | Physical address of the first-level table |
| busy | output | 1 | Walk in progress, requests ignored |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 32 | Entry address for the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Page-table entry returned |
| done_valid | output | 1 | Translation complete (one cycle) |
| done_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | Walk ended in a fault (one cycle) |
| fault_kind | output | 2 | 01 first level invalid, 10 second level invalid, 11 write to read-only page |

## Verification
The hardest case to reach is a walk that is disturbed while it waits on a slow memory. In that case a second request and a changed table root arrive during the wait, and they must leave no trace in the read addresses, the read count or the outcome. The bench models memory with a response delay it can set per walk. It stretches one walk to several idle cycles and holds a conflicting request and a different root on the inputs during that window. It then checks both read addresses and the final result against the undisturbed walk.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [2*IDX_W+OFF_W-1:0]     req_vaddr,
  input  logic                         req_write,
  input  logic [PA_W-1:0]              root_base,
  output logic                         busy,
  output logic                         mem_rd_en,
  output logic [PA_W-1:0]              mem_rd_addr,
  input  logic                         mem_rd_valid,
  input  logic [PA_W-1:0]              mem_rd_data,
  output logic                         done_valid,
  output logic [PA_W-1:0]              done_paddr,
  output logic                         fault_valid,
  output logic [1:0]                   fault_kind
);
  localparam int VA_W  = 2*IDX_W + OFF_W;
  localparam int FR_W  = PA_W - OFF_W;
  localparam int BIT_V = 0;
  localparam int BIT_W = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_RD, S_L1_WT, S_L2_RD, S_L2_WT, S_DONE, S_FAULT
  } walk_t;

  walk_t             state;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [PA_W-1:0]   base_q;
  logic [FR_W-1:0]   frame_q;
  logic [PA_W-1:0]   paddr_q;
  logic [1:0]        kind_q;

  logic [IDX_W-1:0]  idx_hi, idx_lo;
  logic [PA_W-1:0]   l1_addr, l2_addr;

  assign idx_hi  = va_q[VA_W-1 -: IDX_W];
  assign idx_lo  = va_q[OFF_W +: IDX_W];
  assign l1_addr = base_q + PA_W'({idx_hi, 2'b00});
  assign l2_addr = PA_W'({frame_q, idx_lo, 2'b00});

  assign busy        = (state != S_IDLE);
  assign mem_rd_en   = (state == S_L1_RD) || (state == S_L2_RD);
  assign mem_rd_addr = (state == S_L2_RD) ? l2_addr : l1_addr;
  assign done_valid  = (state == S_DONE);
  assign fault_valid = (state == S_FAULT);
  assign done_paddr  = paddr_q;
  assign fault_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      frame_q <= '0;
      paddr_q <= '0;
      kind_q  <= 2'b00;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          base_q <= root_base;
          kind_q <= 2'b00;
          state  <= S_L1_RD;
        end
        S_L1_RD: state <= S_L1_WT;
        S_L1_WT: if (mem_rd_valid) begin
          if (!mem_rd_data[BIT_V]) begin
            kind_q <= 2'b01;
            state  <= S_FAULT;
          end else begin
            frame_q <= mem_rd_data[PA_W-1:OFF_W];
            state   <= S_L2_RD;
          end
        end
        S_L2_RD: state <= S_L2_WT;
        S_L2_WT: if (mem_rd_valid) begin
          if (!mem_rd_data[BIT_V]) begin
            kind_q <= 2'b10;
            state  <= S_FAULT;
          end else if (wr_q && !mem_rd_data[BIT_W]) begin
            kind_q <= 2'b11;
            state  <= S_FAULT;
          end else begin
            paddr_q <= {mem_rd_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
            state   <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        S_FAULT: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  input logic                     busy,
  input logic                     mem_rd_en,
  input logic                     mem_rd_valid,
  input logic                     done_valid,
  input logic [PA_W-1:0]          done_paddr,
  input logic                     fault_valid,
  input logic [1:0]               fault_kind
);
  logic [OFF_W-1:0] off_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (req_valid && !busy) off_q <= req_vaddr[OFF_W-1:0];
      if (mem_rd_en) pend_q <= 1'b1;
      else if (mem_rd_valid) pend_q <= 1'b0;
    end
  end

  p_outcome_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && fault_valid));
  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_paddr[OFF_W-1:0] == off_q);
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid || fault_valid) |=> !busy);
  p_single_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !pend_q);
  p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> fault_kind != 2'b00);
endmodule

bind ptw_walker ptw_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_valid(mem_rd_valid),
  .done_valid(done_valid), .done_paddr(done_paddr),
  .fault_valid(fault_valid), .fault_kind(fault_kind)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0, root_base = BASE;
  logic busy, mem_rd_en, done_valid, fault_valid;
  logic [31:0] mem_rd_addr, done_paddr;
  logic [1:0] fault_kind;
  logic mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #4 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .root_base(root_base), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done_valid(done_valid), .done_paddr(done_paddr),
    .fault_valid(fault_valid), .fault_kind(fault_kind)
  );

  logic [31:0] mem [logic [31:0]];
  int          lat = 0;
  int          cnt = 0;
  logic        pend = 1'b0;
  logic [31:0] pa = '0;
  int          nreads = 0;
  logic [31:0] hist [64];

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= peek(pa);
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (mem_rd_en) begin
      pend <= 1'b1;
      cnt  <= lat;
      pa   <= mem_rd_addr;
      hist[nreads & 63] <= mem_rd_addr;
      nreads <= nreads + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {vaddr, write, kind, paddr, latency}
  localparam logic [69:0] VEC [8] = '{
    {32'h0040_5123, 1'b0, 2'd0, 32'hABCD_E123, 3'd0},
    {32'h0040_5123, 1'b1, 2'd0, 32'hABCD_E123, 3'd2},
    {32'h0040_6FFF, 1'b0, 2'd0, 32'h1234_5FFF, 3'd1},
    {32'h0040_6000, 1'b1, 2'd3, 32'h0,         3'd0},
    {32'h00C0_0777, 1'b0, 2'd1, 32'h0,         3'd3},
    {32'h0040_7010, 1'b1, 2'd2, 32'h0,         3'd4},
    {32'h0080_0000, 1'b1, 2'd0, 32'hFFFF_F000, 3'd0},
    {32'h00BF_FABC, 1'b0, 2'd0, 32'h0000_1ABC, 3'd7}
  };

  logic        got_done, got_fault;
  logic [31:0] got_pa;
  logic [1:0]  got_kind;
  int          start_reads;

  task automatic launch(input logic [31:0] va, input logic wr, input int l);
    @(negedge clk);
    lat = l;
    start_reads = nreads;
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk();
    got_done = 0; got_fault = 0; got_pa = '0; got_kind = '0;
    for (int t = 0; t < 200; t++) begin
      if (done_valid || fault_valid) begin
        chk(!(done_valid && fault_valid), "R10 exclusive outcome", {30'd0, done_valid, fault_valid}, 32'd1);
        got_done = done_valid; got_fault = fault_valid;
        got_pa = done_paddr; got_kind = fault_kind;
        @(negedge clk);
        chk(!busy, "R8 busy released", {31'd0, busy}, 32'd0);
        chk(!done_valid && !fault_valid, "R10 one-cycle outcome", {30'd0, done_valid, fault_valid}, 32'd0);
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, "R9 walk timeout", 32'd0, 32'd1);
  endtask

  task automatic check_walk(input logic [31:0] va, input logic wr, input logic [1:0] kind, input logic [31:0] exp_pa);
    logic [31:0] l1a, l2a;
    int nr;
    l1a = BASE + {20'd0, va[31:22], 2'b00};
    l2a = {peek(l1a)[31:12], va[21:12], 2'b00};
    nr  = nreads - start_reads;
    chk(hist[start_reads & 63] == l1a, "R2 first-level address", hist[start_reads & 63], l1a);
    if (kind == 2'd0) begin
      chk(got_done && got_pa == exp_pa, "R4 translated address", got_pa, exp_pa);
      if (wr) chk(got_done, "R7 write allowed", {31'd0, got_done}, 32'd1);
    end else begin
      chk(got_fault && got_kind == kind, (kind == 2'd1) ? "R5 l1 fault" : (kind == 2'd2) ? "R6 l2 fault" : "R7 protection fault",
          {30'd0, got_kind}, {30'd0, kind});
    end
    if (kind == 2'd1) chk(nr == 1, "R5 no second read", nr, 32'd1);
    else begin
      chk(nr == 2, "R9 two reads", nr, 32'd2);
      chk(hist[(start_reads + 1) & 63] == l2a, "R3 second-level address", hist[(start_reads + 1) & 63], l2a);
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0001_0008] = 32'h0003_0003;
    mem[32'h0002_0014] = 32'hABCD_E003;
    mem[32'h0002_0018] = 32'h1234_5001;
    mem[32'h0003_0000] = 32'hFFFF_F003;
    mem[32'h0003_0FFC] = 32'h0000_1001;

    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd_en && !done_valid && !fault_valid, "R1 state in reset",
        {28'd0, busy, mem_rd_en, done_valid, fault_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd_en && !done_valid && !fault_valid, "R1 state after reset",
        {28'd0, busy, mem_rd_en, done_valid, fault_valid}, 32'd0);

    foreach (VEC[i]) begin
      launch(VEC[i][69:38], VEC[i][37], int'(VEC[i][2:0]));
      finish_walk();
      check_walk(VEC[i][69:38], VEC[i][37], VEC[i][36:35], VEC[i][34:3]);
    end

    // R8: request and root change while busy are ignored
    launch(32'h0040_5123, 1'b0, 6);
    for (int k = 0; k < 4; k++) begin
      req_valid = 1'b1; req_vaddr = 32'h00C0_0777; root_base = 32'hDEAD_0000;
      chk(busy, "R8 busy during walk", {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
    req_valid = 1'b0; root_base = BASE;
    finish_walk();
    check_walk(32'h0040_5123, 1'b0, 2'd0, 32'hABCD_E123);
    repeat (10) @(negedge clk);
    chk(nreads - start_reads == 2, "R8 no walk from ignored request", nreads - start_reads, 32'd2);
    chk(!busy, "R8 idle afterwards", {31'd0, busy}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule